// File: doc/BRIEF.md
# Sleep and Idle Power Controller

This block is a power-mode sequencer placed next to a CPU core. When the core signals a sleep request, the controller either gates only the CPU clock (idle) or gates both the CPU clock and the peripheral clock (sleep). In sleep it also stops the primary oscillator, unless an oscillator-keep bit asks for it to keep running. An enabled interrupt or a reset event brings the block back to run. The controller then reports where the core resumes: the reset vector, the interrupt vector, or the instruction after the sleep request.

On a wake from sleep with the primary oscillator stopped, the controller waits for the oscillator-ready flag. With two-speed start-up enabled, the CPU runs on the internal clock while it waits. The switch to the primary clock is made behind a one-cycle gap in the CPU clock enable, so the clock selection never changes while the clock is enabled. The oscillator itself is outside the block and appears only as a ready input.

Top module: `sleep_idle_ctrl`

## Requirements
- R1: While reset is held, and after it is released: `mode` is RUN (0); `cpu_clk_en`, `per_clk_en`, `pri_osc_en` and `clk_sel` (1 = primary oscillator) are 1; `resume_tgt` is 2 (reset vector); `resume_vld`, `slp_flag` and `idl_flag` are 0.
- R2: A `sleep_req` in RUN with `idle_en`=0, no enabled interrupt pending and no `wake_rst` gives, in the next cycle: `mode`=SLEEP (2), `cpu_clk_en`=0, `per_clk_en`=0, `pri_osc_en` equal to `osc_keep`, and `slp_flag` set.
- R3: The same request with `idle_en`=1 gives, in the next cycle: `mode`=IDLE (1), `cpu_clk_en`=0, `per_clk_en`=1, `pri_osc_en`=1, and `idl_flag` set.
- R4: A `sleep_req` while some `irq_req[i]&irq_en[i]` is already 1 leaves `mode` at RUN. In the next cycle `resume_vld` pulses, with `resume_tgt` 1 if `gie`=1 and 0 if `gie`=0.
- R5: In IDLE or SLEEP, an interrupt request whose enable bit is 0 has no effect on `mode`. An enabled request moves `mode` to WAKING (3), and the resume target is 1 (interrupt vector) when `gie`=1 and 0 (next instruction) when `gie`=0.
- R6: `wake_rst` wakes the block from IDLE or SLEEP and sets `resume_tgt` to 2, taking priority over any interrupt. In RUN it makes `resume_vld` pulse in the next cycle with target 2.
- R7: While WAKING with the primary clock not selected: `cpu_clk_en` equals `two_speed` (CPU runs on the internal clock, `clk_sel`=0) in every cycle up to and including the first cycle in which `osc_rdy` is seen high.
- R8: After `osc_rdy` is seen, one cycle follows with `cpu_clk_en`=0, and then `mode` becomes RUN with `clk_sel`=1. `clk_sel` only rises after a cycle in which `cpu_clk_en` was 0. A wake with the primary clock still selected (from idle, or with the oscillator kept) takes a single WAKING cycle.
- R9: Each wake gives exactly one `resume_vld` pulse, in the first cycle in which `cpu_clk_en` is 1, and `resume_vld` is never high while `cpu_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| idle_en | input | 1 | 1 selects idle instead of sleep |
| osc_keep | input | 1 | Keep the primary oscillator running in sleep |
| two_speed | input | 1 | Let the CPU run on the internal clock during start-up |
| gie | input | 1 | Global interrupt enable |
| wake_rst | input | 1 | Reset event (wakes, targets reset vector) |
| osc_rdy | input | 1 | Primary oscillator ready |
| irq_req | input | NIRQ | Interrupt requests |
| irq_en | input | NIRQ | Per-source interrupt enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| clk_sel | output | 1 | Clock source: 1 primary, 0 internal |
| resume_vld | output | 1 | Resume target valid pulse |
| resume_tgt | output | 2 | 0 next instruction, 1 interrupt vector, 2 reset vector |
| mode | output | 2 | 0 RUN, 1 IDLE, 2 SLEEP, 3 WAKING |
| slp_flag | output | 1 | Sticky: sleep was entered |
| idl_flag | output | 1 | Sticky: idle was entered |

## Verification
The hardest state to reach from the ports is the glitch-free handover: a wake from sleep with the oscillator stopped and two-speed start-up on, where the CPU runs on the internal clock until the ready flag arrives. The bench models the oscillator as a counter that saturates a programmable number of cycles after `pri_osc_en` rises. It sweeps that delay together with idle, keep, two-speed, global enable and the wake source. For each combination it computes the expected number of WAKING cycles and CPU-enabled cycles, and the position of the single resume pulse.

// File: rtl/sleep_idle_ctrl.sv
module sleep_idle_ctrl #(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic            idle_en,
  input  logic            osc_keep,
  input  logic            two_speed,
  input  logic            gie,
  input  logic            wake_rst,
  input  logic            osc_rdy,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            pri_osc_en,
  output logic            clk_sel,
  output logic            resume_vld,
  output logic [1:0]      resume_tgt,
  output logic [1:0]      mode,
  output logic            slp_flag,
  output logic            idl_flag
);
  typedef enum logic [1:0] {S_RUN = 2'd0, S_IDLE = 2'd1, S_SLEEP = 2'd2, S_WAKE = 2'd3} st_t;
  localparam logic [1:0] T_NEXT = 2'd0;
  localparam logic [1:0] T_ISR  = 2'd1;
  localparam logic [1:0] T_RST  = 2'd2;

  st_t        st;
  logic       gap, pend;
  logic [1:0] tgt;
  logic       irq_hit;
  logic [1:0] irq_tgt;

  assign irq_hit = |(irq_req & irq_en);
  assign irq_tgt = gie ? T_ISR : T_NEXT;

  assign cpu_clk_en = (st == S_RUN) | ((st == S_WAKE) & ~clk_sel & two_speed & ~gap);
  assign per_clk_en = (st == S_RUN) | (st == S_IDLE) |
                      ((st == S_WAKE) & (clk_sel ? osc_rdy : (two_speed & ~gap)));
  assign pri_osc_en = (st != S_SLEEP) | osc_keep;
  assign resume_vld = pend & cpu_clk_en;
  assign resume_tgt = tgt;
  assign mode       = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RUN;
      clk_sel  <= 1'b1;
      gap      <= 1'b0;
      pend     <= 1'b0;
      tgt      <= T_RST;
      slp_flag <= 1'b0;
      idl_flag <= 1'b0;
    end else begin
      if (resume_vld) pend <= 1'b0;
      case (st)
        S_RUN: begin
          if (wake_rst) begin
            tgt  <= T_RST;
            pend <= 1'b1;
          end else if (sleep_req) begin
            if (irq_hit) begin
              tgt  <= irq_tgt;
              pend <= 1'b1;
            end else if (idle_en) begin
              st       <= S_IDLE;
              idl_flag <= 1'b1;
            end else begin
              st       <= S_SLEEP;
              slp_flag <= 1'b1;
              clk_sel  <= clk_sel & osc_keep;
            end
          end
        end
        S_IDLE, S_SLEEP: begin
          if (st == S_SLEEP) clk_sel <= clk_sel & osc_keep;
          if (wake_rst || irq_hit) begin
            st   <= S_WAKE;
            pend <= 1'b1;
            tgt  <= wake_rst ? T_RST : irq_tgt;
          end
        end
        default: begin
          if (wake_rst) begin
            tgt  <= T_RST;
            pend <= 1'b1;
          end
          if (gap) begin
            clk_sel <= 1'b1;
            gap     <= 1'b0;
            st      <= S_RUN;
          end else if (osc_rdy) begin
            if (clk_sel) st <= S_RUN;
            else         gap <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sleep_idle_ctrl_chk.sv
module sleep_idle_ctrl_chk #(
  parameter int NIRQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sleep_req,
  input logic            idle_en,
  input logic            gie,
  input logic            wake_rst,
  input logic [NIRQ-1:0] irq_req,
  input logic [NIRQ-1:0] irq_en,
  input logic            cpu_clk_en,
  input logic            per_clk_en,
  input logic            clk_sel,
  input logic            resume_vld,
  input logic [1:0]      resume_tgt,
  input logic [1:0]      mode
);
  logic hit;
  assign hit = |(irq_req & irq_en);

  // R2
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sleep_req && !idle_en && !hit && !wake_rst) |=>
    (mode == 2'd2 && !cpu_clk_en && !per_clk_en));

  // R3
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sleep_req && idle_en && !hit && !wake_rst) |=>
    (mode == 2'd1 && !cpu_clk_en && per_clk_en));

  // R4
  early_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sleep_req && hit && !wake_rst) |=>
    (mode == 2'd0 && resume_vld && resume_tgt == $past({1'b0, gie})));

  // R6
  rst_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |=> (resume_tgt == 2'd2));

  // R8
  switch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) |-> !$past(cpu_clk_en));

  // R9
  vld_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_vld |-> cpu_clk_en);

  // R9
  vld_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_vld && !wake_rst && !sleep_req) |=> !resume_vld);
endmodule

bind sleep_idle_ctrl sleep_idle_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_en(idle_en), .gie(gie),
  .wake_rst(wake_rst), .irq_req(irq_req), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .clk_sel(clk_sel), .resume_vld(resume_vld),
  .resume_tgt(resume_tgt), .mode(mode)
);

// File: tb/test_sleep_idle_ctrl.sv
`timescale 1ns/1ps
module test_sleep_idle_ctrl;
  localparam int NIRQ = 4;
  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, idle_en = 0, osc_keep = 0, two_speed = 0, gie = 0, wake_rst = 0;
  logic osc_rdy;
  logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
  logic cpu_clk_en, per_clk_en, pri_osc_en, clk_sel, resume_vld, slp_flag, idl_flag;
  logic [1:0] resume_tgt, mode;
  int errors = 0, checks = 0, dly = 2, cnt = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk)
    cnt <= !pri_osc_en ? 0 : (cnt >= dly ? cnt : cnt + 1);
  assign osc_rdy = pri_osc_en && (cnt >= dly);

  sleep_idle_ctrl #(.NIRQ(NIRQ)) i_sleep_idle_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_en(idle_en), .osc_keep(osc_keep),
    .two_speed(two_speed), .gie(gie), .wake_rst(wake_rst), .osc_rdy(osc_rdy),
    .irq_req(irq_req), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .pri_osc_en(pri_osc_en), .clk_sel(clk_sel), .resume_vld(resume_vld),
    .resume_tgt(resume_tgt), .mode(mode), .slp_flag(slp_flag), .idl_flag(idl_flag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input bit idl, input bit keep, input bit ts, input bit g, input bit by_rst, input int d);
    int w = 0, on = 0, nv = 0, vt = -1, last_cpu = 1;
    bit slow;
    dly = d; idle_en = idl; osc_keep = keep; two_speed = ts; gie = g;
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    chk(idl ? "R3 mode" : "R2 mode", mode, idl ? 1 : 2);
    chk("R2/R3 cpu gated", cpu_clk_en, 0);
    chk(idl ? "R3 per" : "R2 per", per_clk_en, idl);
    chk("R2/R3 osc en", pri_osc_en, idl | keep);
    chk(idl ? "R3 flag" : "R2 flag", idl ? idl_flag : slp_flag, 1);
    irq_req = 4'b0001; irq_en = 4'b0000;
    repeat (2) @(negedge clk);
    chk("R5 disabled irq ignored", mode, idl ? 1 : 2);
    irq_req = '0;
    repeat (d + 3) @(negedge clk);
    if (by_rst) begin wake_rst = 1; irq_req = 4'b0100; irq_en = 4'b0100; end
    else begin irq_req = 4'b0100; irq_en = 4'b0100; end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      wake_rst = 0; irq_req = '0; irq_en = '0;
      if (resume_vld) begin nv++; vt = resume_tgt; end
      if (mode == 2'd0) break;
      w++; on += cpu_clk_en; last_cpu = cpu_clk_en;
    end
    slow = !idl && !keep;
    chk("R5/R8 waking cycles", w, slow ? d + 2 : 1);
    chk("R7 cpu on internal clock", on, (slow && ts) ? d + 1 : 0);
    chk("R8 gap before switch", last_cpu, 0);
    chk("R8 primary selected", clk_sel, 1);
    chk("R9 single resume pulse", nv, 1);
    chk(by_rst ? "R6 target" : "R5 target", vt, by_rst ? 2 : (g ? 1 : 0));
    @(negedge clk);
    chk("R9 no second pulse", resume_vld, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 clk enables", {cpu_clk_en, per_clk_en, pri_osc_en, clk_sel}, 15);
    chk("R1 target", resume_tgt, 2);
    chk("R1 vld/flags", {resume_vld, slp_flag, idl_flag}, 0);
    rst_n = 1;
    repeat (dly + 3) @(negedge clk);
    chk("R1 after release", {mode, resume_vld}, 0);
    wake_rst = 1;
    @(negedge clk); wake_rst = 0;
    chk("R6 run pulse", resume_vld, 1);
    chk("R6 run target", resume_tgt, 2);
    for (int g = 0; g < 2; g++) begin
      gie = g[0]; irq_req = 4'b1000; irq_en = 4'b1000; sleep_req = 1;
      @(negedge clk); sleep_req = 0; irq_req = '0; irq_en = '0;
      chk("R4 stays run", mode, 0);
      chk("R4 pulse", resume_vld, 1);
      chk("R4 target", resume_tgt, g);
      @(negedge clk);
    end
    for (int idl = 0; idl < 2; idl++)
      for (int keep = 0; keep < 2; keep++)
        for (int ts = 0; ts < 2; ts++)
          for (int g = 0; g < 2; g++)
            for (int src = 0; src < 2; src++)
              for (int d = 1; d < 7; d += 2)
                run_case(idl[0], keep[0], ts[0], g[0], src[0], d);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule